// File: doc/BRIEF.md
# Embedded-Clock Word Serializer with Sync Bursts

This block turns a 10-bit parallel word into a 12-bit serial frame, one bit per fast clock. Each frame carries one start bit, the ten payload bits and one stop bit, so the receiver always sees a rising edge at the frame boundary and can recover the word clock from the line alone. The word clock is modelled inside the block by a phase counter over the fast clock. A pulse on `word_tick` marks the last bit cycle of each frame, and `data_in` is captured at the end of that cycle.

After reset, and again after power-down ends, the block sends 1024 initialization frames before it carries any payload. `ready` reports when that period is over. Two independent sync-request inputs let separate receivers on a shared link ask for relock. A request on either input replaces the payload with sync frames for at least 1024 frames. The burst is extended for as long as a request is still present at frame boundaries. While power-down is active, the line is held low and the block stays quiet.

Top module: `eclk_serializer`

## Requirements
- R1: Each frame is 12 bits sent least significant first. Bit 0 is a start bit of 1, bits 1 to 10 carry `data_in[0]` to `data_in[9]`, and bit 11 is a stop bit of 0.
- R2: Frames follow each other with no gap, one every 12 clock cycles. `word_tick` is high only in the cycle that carries bit 11, and `data_in` is sampled at the end of that cycle.
- R3: After reset or power-down release, the first 1024 frames are initialization frames with value 12'h001 (a start bit, then zeros), whatever `data_in` holds. `ready` is low until the last of them has been loaded, and high from then on.
- R4: A sync frame has value 12'h03F: six ones followed by six zeros.
- R5: A request seen at one frame boundary after initialization produces exactly 1024 sync frames, starting with the frame loaded at that boundary.
- R6: Each boundary at which a request is present restarts the count. The burst therefore ends 1023 frames after the last boundary that saw a request.
- R7: A request present in any cycle between boundaries is remembered and takes effect at the next boundary. A request made during initialization is held, and its burst starts with the first frame after initialization.
- R8: While `power_down` is high, from the next clock edge on, `ser_out`, `ready` and `word_tick` are low, and initialization restarts when it drops.
- R9: `sync_a` and `sync_b` are independent: either one alone starts or extends a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| power_down | input | 1 | Active-high power-down request |
| data_in | input | 10 | Parallel payload word |
| sync_a | input | 1 | Sync request, first source |
| sync_b | input | 1 | Sync request, second source |
| ser_out | output | 1 | Serial line output |
| word_tick | output | 1 | Word clock: high in the last bit cycle of each frame |
| ready | output | 1 | Initialization complete |

## Verification
A one-cycle request placed in the middle of a frame is the main corner case. A design that only sampled the inputs at the boundary would lose the request, and one that counted the boundary frame twice would give 1025 sync frames instead of 1024. A request held on the second input for about 250 frames checks that the burst ends exactly 1023 frames after the last boundary that saw it; a design that did not restart the count would end the burst too early. A pulse during the re-initialization that follows power-down must delay its burst until the init frames are done. Payload is compared frame by frame while `data_in` changes every cycle, so capturing the word one cycle late or in the wrong bit order shows up at once.

// File: rtl/eclk_pkg.sv
// Shared types for the embedded-clock serializer.
package eclk_pkg;
    // Which kind of frame is loaded at a word boundary.
    typedef enum logic [1:0] {
        FK_INIT = 2'd0,
        FK_SYNC = 2'd1,
        FK_DATA = 2'd2
    } frame_kind_e;
endpackage

// File: rtl/eclk_phase_ctr.sv
// Word-phase counter: divides the bit clock by FRAME_W.
// It stands in for the word clock and the clock multiplier.
// Assumes a synchronous active-low reset. Power-down parks the
// counter on the last phase, so the first edge after release
// loads a new frame.
module eclk_phase_ctr #(
    parameter int FRAME_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_down,
    output logic boundary
);
    localparam int PW = $clog2(FRAME_W);
    localparam logic [PW-1:0] LAST = PW'(FRAME_W - 1);

    logic [PW-1:0] phase;

    // Advance the bit position and wrap at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || power_down) begin
            phase <= LAST;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign boundary = (phase == LAST);

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !power_down) |=> (phase == '0));
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !power_down) |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/eclk_seq_ctl.sv
// Frame sequencer. At each word boundary it picks the kind of frame
// to load next: initialization, sync or payload.
// Assumes `boundary` is high for one cycle per frame. Requests
// between boundaries are held in a pending flag.
module eclk_seq_ctl
    import eclk_pkg::*;
#(
    parameter int INIT_LEN = 1024,
    parameter int SYNC_MIN = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        power_down,
    input  logic        boundary,
    input  logic        sync_a,
    input  logic        sync_b,
    output frame_kind_e kind,
    output logic        ready
);
    localparam int IW = $clog2(INIT_LEN + 1);
    localparam int SW = (SYNC_MIN > 1) ? $clog2(SYNC_MIN) : 1;
    localparam logic [IW-1:0] INIT_END = IW'(INIT_LEN);
    localparam logic [SW-1:0] REM_TOP = SW'(SYNC_MIN - 1);

    logic [IW-1:0] init_cnt;
    logic [SW-1:0] sync_rem;
    logic          pend;
    logic          init_active;
    logic          req;

    assign init_active = (init_cnt != INIT_END);
    assign req         = pend | sync_a | sync_b;
    assign ready       = !init_active && !power_down;

    // Choose the next frame: init has priority, then sync, then payload.
    always_comb begin
        if (init_active) begin
            kind = FK_INIT;
        end else if (req || (sync_rem != '0)) begin
            kind = FK_SYNC;
        end else begin
            kind = FK_DATA;
        end
    end

    // Count init frames, run the burst counter and hold pending requests.
    always_ff @(posedge clk) begin
        if (!rst_n || power_down) begin
            init_cnt <= '0;
            sync_rem <= '0;
            pend     <= 1'b0;
        end else if (boundary) begin
            unique case (kind)
                FK_INIT: begin
                    init_cnt <= init_cnt + 1'b1;
                    pend     <= req;
                end
                FK_SYNC: begin
                    sync_rem <= req ? REM_TOP : sync_rem - 1'b1;
                    pend     <= 1'b0;
                end
                default: pend <= 1'b0;
            endcase
        end else begin
            pend <= req;
        end
    end

    assert_ready_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (ready || power_down));
    assert_burst_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ready && (sync_a || sync_b)) |=> (sync_rem == REM_TOP));
    assert_init_holds_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !ready && !power_down && (sync_a || sync_b)) |=> pend);
endmodule

// File: rtl/eclk_frame_shifter.sv
// Frame builder and shift register. At a boundary it loads the frame
// picked by the sequencer, then shifts one bit per clock, LSB first.
// Assumes `kind` and `data_in` are valid in the boundary cycle.
// Power-down clears the register, so the line stays low.
module eclk_frame_shifter
    import eclk_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_down,
    input  logic              boundary,
    input  frame_kind_e       kind,
    input  logic [DATA_W-1:0] data_in,
    output logic              ser_out
);
    localparam int FW = DATA_W + 2;
    localparam int HIGH_BITS = FW / 2;

    logic [FW-1:0] sync_word;
    logic [FW-1:0] next_frame;
    logic [FW-1:0] sreg;

    // Sync pattern: ones in the low half, zeros in the high half.
    for (genvar i = 0; i < FW; i++) begin : g_sync
        assign sync_word[i] = (i < HIGH_BITS);
    end

    // Build the frame to load at the next boundary.
    always_comb begin
        unique case (kind)
            FK_INIT: next_frame = FW'(1);
            FK_SYNC: next_frame = sync_word;
            default: next_frame = {1'b0, data_in, 1'b1};
        endcase
    end

    // Load at the boundary, otherwise shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || power_down) begin
            sreg <= '0;
        end else if (boundary) begin
            sreg <= next_frame;
        end else begin
            sreg <= sreg >> 1;
        end
    end

    assign ser_out = sreg[0];

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !power_down) |=> ser_out);
    assert_stop_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !power_down) |-> !ser_out);
    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(power_down) |-> !ser_out);
endmodule

// File: rtl/eclk_serializer.sv
// Embedded-clock word serializer (top level).
// Joins the phase counter, the sequencer and the shifter.
// Assumes one fast clock per line bit. Word clock output is the
// boundary strobe, gated off during power-down.
module eclk_serializer
    import eclk_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int INIT_LEN = 1024,
    parameter int SYNC_MIN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_down,
    input  logic [DATA_W-1:0] data_in,
    input  logic              sync_a,
    input  logic              sync_b,
    output logic              ser_out,
    output logic              word_tick,
    output logic              ready
);
    localparam int FRAME_W = DATA_W + 2;

    logic        boundary;
    frame_kind_e kind;

    eclk_phase_ctr #(.FRAME_W(FRAME_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_down (power_down),
        .boundary   (boundary)
    );

    eclk_seq_ctl #(.INIT_LEN(INIT_LEN), .SYNC_MIN(SYNC_MIN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_down (power_down),
        .boundary   (boundary),
        .sync_a     (sync_a),
        .sync_b     (sync_b),
        .kind       (kind),
        .ready      (ready)
    );

    eclk_frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_down (power_down),
        .boundary   (boundary),
        .kind       (kind),
        .data_in    (data_in),
        .ser_out    (ser_out)
    );

    // Word clock seen by the data source.
    assign word_tick = boundary && !power_down;

    assert_tick_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> (!word_tick && !ready));
endmodule

// File: tb/eclk_serializer_bench.sv
// Scoreboard bench. The model pushes expected frames at each word tick;
// the monitor rebuilds frames from the line and compares them.
module eclk_serializer_bench;
    import eclk_pkg::*;

    localparam int DW = 10;
    localparam int FW = DW + 2;
    localparam int INIT_LEN = 1024;
    localparam int SYNC_MIN = 1024;
    localparam logic [FW-1:0] SYNC_PAT = 12'h03F;
    localparam logic [FW-1:0] INIT_PAT = 12'h001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic power_down = 1'b0;
    logic sync_a = 1'b0;
    logic sync_b = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic ser_out, word_tick, ready;

    always #5 clk = ~clk;

    eclk_serializer #(.DATA_W(DW), .INIT_LEN(INIT_LEN), .SYNC_MIN(SYNC_MIN)) u_eclk_serializer (
        .clk(clk), .rst_n(rst_n), .power_down(power_down), .data_in(data_in),
        .sync_a(sync_a), .sync_b(sync_b), .ser_out(ser_out),
        .word_tick(word_tick), .ready(ready)
    );

    int nchk = 0;
    int nbad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [FW-1:0] bits;
        frame_kind_e   kind;
    } exp_t;
    exp_t q[$];

    // Model state.
    int binit, brem, m_hits, gap;
    bit bpend, seen_tick, req;
    // Monitor state.
    bit col, tick_prev;
    int idx, run, last_run, n_runs, n_init_obs;
    logic [FW-1:0] fr;
    frame_kind_e prev_kind, post_init_kind;
    exp_t e;

    // Data source: a new word every cycle, or a fixed pattern.
    bit use_fixed = 1'b0;
    logic [DW-1:0] fixed_val = '0;
    always @(posedge clk) begin
        #1 data_in <= use_fixed ? fixed_val : DW'($urandom);
    end

    // Monitor first, then model, all in one process at the falling edge.
    always @(negedge clk) begin
        if (!rst_n || power_down) begin
            q.delete();
            binit = 0; brem = 0; bpend = 0; col = 0; tick_prev = 0;
            seen_tick = 0; run = 0; n_init_obs = 0; prev_kind = FK_INIT;
        end else begin
            if (tick_prev) begin col = 1; idx = 0; end
            if (col) begin
                fr[idx] = ser_out;
                if (idx == FW - 1) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R1 frame with none expected", int'(fr), 0);
                    end else begin
                        e = q.pop_front();
                        case (e.kind)
                            FK_INIT: chk(fr == e.bits, "R3 init frame", int'(fr), int'(e.bits));
                            FK_SYNC: chk(fr == e.bits, "R4 sync frame", int'(fr), int'(e.bits));
                            default: chk(fr == e.bits, "R1 data frame", int'(fr), int'(e.bits));
                        endcase
                        if (e.kind == FK_INIT) n_init_obs++;
                        if (prev_kind == FK_INIT && e.kind != FK_INIT) post_init_kind = e.kind;
                        prev_kind = e.kind;
                        if (e.kind == FK_SYNC) run++;
                        else if (run > 0) begin last_run = run; run = 0; n_runs++; end
                    end
                end
                idx++;
            end
            gap++;
            if (word_tick) begin
                if (seen_tick) chk(gap == FW, "R2 word period", gap, FW);
                seen_tick = 1; gap = 0;
                chk(ready == (binit == INIT_LEN), "R3 ready at tick", int'(ready), int'(binit == INIT_LEN));
                req = bpend | sync_a | sync_b;
                if (binit < INIT_LEN) begin
                    q.push_back('{INIT_PAT, FK_INIT}); binit++; bpend = req;
                end else if (req || brem > 0) begin
                    q.push_back('{SYNC_PAT, FK_SYNC});
                    if (req) m_hits++;
                    brem = req ? SYNC_MIN - 1 : brem - 1;
                    bpend = 0;
                end else begin
                    q.push_back('{{1'b0, data_in, 1'b1}, FK_DATA}); bpend = 0;
                end
            end else begin
                bpend = bpend | sync_a | sync_b;
            end
            tick_prev = word_tick;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int k;
        logic [DW-1:0] pats [4];
        pats[0] = 10'h000; pats[1] = 10'h3FF; pats[2] = 10'h155; pats[3] = 10'h2AA;
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b0, "R3 reset line low", int'(ser_out), 0);
        chk(ready == 1'b0, "R3 reset ready low", int'(ready), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R3: initialization, then random payload and fixed patterns (R1).
        wait (ready);
        cycles(30 * FW);
        for (int i = 0; i < 4; i++) begin
            use_fixed = 1'b1; fixed_val = pats[i];
            cycles(3 * FW);
        end
        use_fixed = 1'b0;
        chk(n_init_obs == INIT_LEN, "R3 init frame count", n_init_obs, INIT_LEN);

        // R5, R7, R9: one-cycle request on sync_a, placed mid-frame.
        @(negedge clk iff word_tick);
        @(posedge clk); #1 sync_a = 1'b1;
        @(posedge clk); #1 sync_a = 1'b0;
        k = n_runs;
        wait (n_runs == k + 1);
        chk(last_run == SYNC_MIN, "R5 R7 R9 single-request burst length", last_run, SYNC_MIN);
        cycles(10 * FW);

        // R6, R9: request held on sync_b extends the burst.
        m_hits = 0;
        @(posedge clk); #1 sync_b = 1'b1;
        cycles(3000);
        sync_b = 1'b0;
        k = n_runs;
        wait (n_runs == k + 1);
        chk(m_hits >= 3000 / FW - 1, "R6 R9 boundaries seen with request", m_hits, 3000 / FW - 1);
        chk(last_run == m_hits + SYNC_MIN - 1, "R6 R9 extended burst length", last_run, m_hits + SYNC_MIN - 1);
        cycles(5 * FW);

        // R8: power-down holds the line, ready and word clock low.
        cycles(5);
        power_down = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!ser_out && !ready && !word_tick, "R8 quiet in power-down",
                int'({ser_out, ready, word_tick}), 0);
        end
        @(posedge clk); #1 power_down = 1'b0;

        // R7: a request during re-initialization waits for init to end.
        cycles(100 * FW + 5);
        chk(ready == 1'b0, "R8 R3 re-init after power-down", int'(ready), 0);
        sync_a = 1'b1;
        cycles(1);
        sync_a = 1'b0;
        k = n_runs;
        wait (n_runs == k + 1);
        chk(post_init_kind == FK_SYNC, "R7 first frame after init is sync", int'(post_init_kind), int'(FK_SYNC));
        chk(last_run == SYNC_MIN, "R7 held request burst length", last_run, SYNC_MIN);
        chk(n_init_obs == INIT_LEN, "R3 R8 init frame count after power-down", n_init_obs, INIT_LEN);
        cycles(10 * FW);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule